// File: doc/BRIEF.md
# UART Oversampling Bit-Rate Generator

This block derives all bit timing for a UART transmitter and receiver from a single input clock. Software programs it through a small byte-wide register port. A 16-bit divisor sets the length of one sample period. A speed-mode register sets the number of samples that make up one bit: a fixed 16, a fixed 4, or a programmable count. In programmable mode a separate register picks the sample inside each bit at which the receiver takes its value.

The block drives three pulses. `sample_tick` fires once per sample period. `bit_tick` fires on the last sample of each bit. `rx_strobe` fires on the chosen receive sample. The block also decodes the two lowest register offsets. While the divisor-access bit of the line control register is set, those offsets reach the divisor bytes. While the bit is clear, a write to either offset is handed on to the neighbouring data or interrupt-enable logic as a one-cycle pulse.

Top module: `uart_baud_gen`

## Requirements
- R1: After reset, the line control register reads 0x00, speed mode reads 0, sample count reads 0x00, sample point reads 0xFF and the divisor reads 0x0000. Word offsets used by the port: 3 is line control, 9 is speed mode (bits 1:0), 10 is sample count and 11 is sample point.
- R2: While line control bit 7 is 1, offsets 0 and 1 read and write the low and high divisor bytes, and `tx_data_wr`/`ier_wr` stay low. While bit 7 is 0, a write to offset 0 pulses `tx_data_wr`, a write to offset 1 pulses `ier_wr`, the divisor is left unchanged, and reads of offsets 0 and 1 return 0.
- R3: A divisor of 0 produces the same timing as a divisor of 1.
- R4: In speed mode 0, and in reserved mode 1, one bit lasts 16 × D clocks, where D is the effective divisor.
- R5: In speed mode 2, one bit lasts 4 × D clocks.
- R6: In speed mode 3, one bit lasts D × (sample_count + 1) clocks.
- R7: `sample_tick` pulses once every D clocks. The first pulse after a restart comes D − 1 clock edges after the restarting write edge.
- R8: In modes 0, 1 and 2, `rx_strobe` fires on sample index 7 (of 16) or sample index 1 (of 4). The sample point register has no effect in these modes.
- R9: In mode 3, `rx_strobe` fires on sample index equal to the sample point register. It never fires when that value exceeds the sample count.
- R10: A write to either divisor byte, to the speed mode or to the sample count restarts the timing. The first `bit_tick` then comes S × D − 1 clock edges after the write edge, where S is the number of samples per bit, and later ones follow every S × D clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 5 | Word offset for the write |
| wr_data | input | 8 | Write data |
| rd_addr | input | 5 | Word offset for the combinational read |
| rd_data | output | 8 | Read data |
| tx_data_wr | output | 1 | Offset 0 written while divisor access is off |
| ier_wr | output | 1 | Offset 1 written while divisor access is off |
| sample_tick | output | 1 | One pulse per sample period |
| bit_tick | output | 1 | Pulse on the last sample of each bit |
| rx_strobe | output | 1 | Pulse on the selected receive sample |

## Verification
The bench builds the block with its default parameters: an 8-bit register port, a 5-bit word offset and therefore a 16-bit divisor and 8-bit sample counters. Sweeping every speed mode against divisors 0 to 5 keeps each bit period within about eighty clocks. This makes it practical to check every edge of the first two bits after each restart. The mode-3 sweep covers sample counts of 1, 2, 4, 8 and 16 samples, with the sample point placed at the start, at mid-bit, at the last sample and out of range.

// File: rtl/uart_baud_pkg.sv
package uart_baud_pkg;

    typedef enum logic [1:0] {
        SPD_X16  = 2'd0,
        SPD_RSVD = 2'd1,
        SPD_X4   = 2'd2,
        SPD_PROG = 2'd3
    } speed_e;

    localparam int OFS_DATA   = 0;
    localparam int OFS_IER    = 1;
    localparam int OFS_LCR    = 3;
    localparam int OFS_SPEED  = 9;
    localparam int OFS_SCOUNT = 10;
    localparam int OFS_SPOINT = 11;

    localparam int LCR_ACCESS_BIT = 7;

    localparam int X16_LAST   = 15;
    localparam int X16_STROBE = 7;
    localparam int X4_LAST    = 3;
    localparam int X4_STROBE  = 1;

endpackage

// File: rtl/baud_regs.sv
module baud_regs
    import uart_baud_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8,
    localparam int DIV_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DIV_W-1:0]  divisor,
    output speed_e            speed,
    output logic [DATA_W-1:0] samp_count,
    output logic [DATA_W-1:0] samp_point,
    output logic              restart,
    output logic              tx_data_wr,
    output logic              ier_wr
);

    typedef struct packed {
        logic [DATA_W-1:0] lcr;
        logic [DIV_W-1:0]  div;
        speed_e            speed;
        logic [DATA_W-1:0] cnt;
        logic [DATA_W-1:0] pt;
    } regs_t;

    regs_t r_q, r_d;

    logic access_q;
    logic hit_lo, hit_hi, hit_lcr, hit_spd, hit_cnt, hit_pt;

    assign access_q = r_q.lcr[LCR_ACCESS_BIT];

    always_comb begin
        hit_lo  = wr_en && (wr_addr == ADDR_W'(OFS_DATA));
        hit_hi  = wr_en && (wr_addr == ADDR_W'(OFS_IER));
        hit_lcr = wr_en && (wr_addr == ADDR_W'(OFS_LCR));
        hit_spd = wr_en && (wr_addr == ADDR_W'(OFS_SPEED));
        hit_cnt = wr_en && (wr_addr == ADDR_W'(OFS_SCOUNT));
        hit_pt  = wr_en && (wr_addr == ADDR_W'(OFS_SPOINT));

        r_d = r_q;
        if (hit_lcr) r_d.lcr = wr_data;
        if (hit_lo && access_q) r_d.div[DATA_W-1:0] = wr_data;
        if (hit_hi && access_q) r_d.div[DIV_W-1:DATA_W] = wr_data;
        if (hit_spd) r_d.speed = speed_e'(wr_data[1:0]);
        if (hit_cnt) r_d.cnt = wr_data;
        if (hit_pt)  r_d.pt = wr_data;

        restart    = ((hit_lo || hit_hi) && access_q) || hit_spd || hit_cnt;
        tx_data_wr = hit_lo && !access_q;
        ier_wr     = hit_hi && !access_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.lcr   <= '0;
            r_q.div   <= '0;
            r_q.speed <= SPD_X16;
            r_q.cnt   <= '0;
            r_q.pt    <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(OFS_DATA) && access_q)
            rd_data = r_q.div[DATA_W-1:0];
        else if (rd_addr == ADDR_W'(OFS_IER) && access_q)
            rd_data = r_q.div[DIV_W-1:DATA_W];
        else if (rd_addr == ADDR_W'(OFS_LCR))
            rd_data = r_q.lcr;
        else if (rd_addr == ADDR_W'(OFS_SPEED))
            rd_data = DATA_W'(r_q.speed);
        else if (rd_addr == ADDR_W'(OFS_SCOUNT))
            rd_data = r_q.cnt;
        else if (rd_addr == ADDR_W'(OFS_SPOINT))
            rd_data = r_q.pt;
    end

    assign divisor    = r_q.div;
    assign speed      = r_q.speed;
    assign samp_count = r_q.cnt;
    assign samp_point = r_q.pt;

    AST_ALIAS_KEEPS_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(OFS_DATA) && !access_q) |=> $stable(divisor)) else $error("alias"); // R2

endmodule

// File: rtl/baud_prescale.sv
module baud_prescale #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] pre;
    } pre_t;

    pre_t p_q, p_d;
    logic [DIV_W-1:0] last_idx;

    always_comb begin
        last_idx = (divisor == '0) ? '0 : divisor - DIV_W'(1);
        tick     = (p_q.pre >= last_idx) && !restart;
        p_d      = p_q;
        if (restart)
            p_d.pre = '0;
        else if (p_q.pre >= last_idx)
            p_d.pre = '0;
        else
            p_d.pre = p_q.pre + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && divisor > DIV_W'(1)) |=> !tick) else $error("gap"); // R7

endmodule

// File: rtl/baud_sampler.sv
module baud_sampler
    import uart_baud_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             tick,
    input  speed_e           speed,
    input  logic [CNT_W-1:0] samp_count,
    input  logic [CNT_W-1:0] samp_point,
    output logic             bit_tick,
    output logic             rx_strobe
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } smp_t;

    smp_t s_q, s_d;
    logic [CNT_W-1:0] last_idx;
    logic [CNT_W-1:0] strobe_idx;

    always_comb begin
        unique case (speed)
            SPD_X4: begin
                last_idx   = CNT_W'(X4_LAST);
                strobe_idx = CNT_W'(X4_STROBE);
            end
            SPD_PROG: begin
                last_idx   = samp_count;
                strobe_idx = samp_point;
            end
            default: begin
                last_idx   = CNT_W'(X16_LAST);
                strobe_idx = CNT_W'(X16_STROBE);
            end
        endcase

        bit_tick  = tick && (s_q.cnt == last_idx);
        rx_strobe = tick && (s_q.cnt == strobe_idx);

        s_d = s_q;
        if (restart)
            s_d.cnt = '0;
        else if (tick)
            s_d.cnt = (s_q.cnt == last_idx) ? '0 : s_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= last_idx) else $error("bound"); // R6

endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
    import uart_baud_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8,
    localparam int DIV_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              tx_data_wr,
    output logic              ier_wr,
    output logic              sample_tick,
    output logic              bit_tick,
    output logic              rx_strobe
);

    logic [DIV_W-1:0]  divisor;
    speed_e            speed;
    logic [DATA_W-1:0] samp_count;
    logic [DATA_W-1:0] samp_point;
    logic              restart;

    baud_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .divisor(divisor), .speed(speed), .samp_count(samp_count),
        .samp_point(samp_point), .restart(restart),
        .tx_data_wr(tx_data_wr), .ier_wr(ier_wr)
    );

    baud_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .divisor(divisor), .tick(sample_tick)
    );

    baud_sampler #(.CNT_W(DATA_W)) u_smp (
        .clk(clk), .rst_n(rst_n), .restart(restart), .tick(sample_tick),
        .speed(speed), .samp_count(samp_count), .samp_point(samp_point),
        .bit_tick(bit_tick), .rx_strobe(rx_strobe)
    );

    AST_BIT_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> sample_tick) else $error("bit"); // R4

    AST_STROBE_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |-> sample_tick) else $error("strobe"); // R9

endmodule

// File: tb/tb_uart_baud_gen.sv
`timescale 1ns/1ps
module tb_uart_baud_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [4:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       tx_data_wr, ier_wr, sample_tick, bit_tick, rx_strobe;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic seen_tx, seen_ier;

    always #2.5 clk = ~clk;

    uart_baud_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tx_data_wr(tx_data_wr), .ier_wr(ier_wr), .sample_tick(sample_tick),
        .bit_tick(bit_tick), .rx_strobe(rx_strobe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = 8'(d);
        #1;
        seen_tx = tx_data_wr; seen_ier = ier_wr;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        rd_addr = 5'(a);
        #1;
        v = int'(rd_data);
    endtask

    task automatic run_cfg(input int mode, input int dv, input int sc, input int sp);
        int d, spb, p, per;
        int first_bit, second_bit, first_st, n_st, n_str, str_pos;
        string rq, rs;
        d   = (dv == 0) ? 1 : dv;
        spb = (mode == 2) ? 4 : (mode == 3) ? sc + 1 : 16;
        p   = (mode == 2) ? 1 : (mode == 3) ? sp : 7;
        per = spb * d;
        rq  = (mode == 2) ? "R5" : (mode == 3) ? "R6" : "R4";
        rs  = (mode == 3) ? "R9" : "R8";
        if (dv == 0) rq = {rq, "/R3"};
        first_bit = -1; second_bit = -1; first_st = -1;
        n_st = 0; n_str = 0; str_pos = -1;
        wr(3, 8'h83); wr(0, dv & 255); wr(1, dv >> 8); wr(3, 8'h03);
        wr(11, sp); wr(10, sc); wr(9, mode);
        for (int k = 0; k < 2 * per; k++) begin
            #1;
            if (bit_tick) begin
                if (first_bit < 0) first_bit = k;
                else if (second_bit < 0) second_bit = k;
            end
            if (k < per) begin
                if (sample_tick) begin
                    n_st++;
                    if (first_st < 0) first_st = k;
                end
                if (rx_strobe) begin
                    n_str++;
                    str_pos = k;
                end
            end
            @(negedge clk);
        end
        chk(first_bit == per - 1, {"R10 first bit ", rq}, first_bit, per - 1);
        chk(second_bit - first_bit == per, {rq, " bit period"}, second_bit - first_bit, per);
        chk(first_st == d - 1, "R7 first sample", first_st, d - 1);
        chk(n_st == spb, "R7 samples per bit", n_st, spb);
        chk(n_str == ((p < spb) ? 1 : 0), {rs, " strobe count"}, n_str, (p < spb) ? 1 : 0);
        if (p < spb)
            chk(str_pos == (p + 1) * d - 1, {rs, " strobe position"}, str_pos, (p + 1) * d - 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int v, fb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset timing: mode 0, divisor 0 acts as 1 -> first bit tick after 15 edges
        fb = -1;
        for (int k = 0; k < 20; k++) begin
            #1;
            if (bit_tick && fb < 0) fb = k;
            @(negedge clk);
        end
        chk(fb == 15, "R1/R3 reset bit timing", fb, 15);
        rd(3, v);  chk(v == 0,   "R1 lcr reset", v, 0);
        rd(9, v);  chk(v == 0,   "R1 speed reset", v, 0);
        rd(10, v); chk(v == 0,   "R1 count reset", v, 0);
        rd(11, v); chk(v == 255, "R1 point reset", v, 255);
        wr(3, 8'h83);
        rd(0, v);  chk(v == 0, "R1 div lo reset", v, 0);
        rd(1, v);  chk(v == 0, "R1 div hi reset", v, 0);

        // R2 aliasing
        wr(0, 8'h34); chk(seen_tx == 1'b0, "R2 no tx pulse with access", int'(seen_tx), 0);
        wr(1, 8'h12); chk(seen_ier == 1'b0, "R2 no ier pulse with access", int'(seen_ier), 0);
        rd(0, v); chk(v == 8'h34, "R2 div lo", v, 8'h34);
        rd(1, v); chk(v == 8'h12, "R2 div hi", v, 8'h12);
        wr(3, 8'h03);
        wr(0, 8'h5A); chk(seen_tx == 1'b1 && seen_ier == 1'b0, "R2 tx pulse", int'(seen_tx), 1);
        wr(1, 8'hA5); chk(seen_ier == 1'b1 && seen_tx == 1'b0, "R2 ier pulse", int'(seen_ier), 1);
        rd(0, v); chk(v == 0, "R2 data offset reads 0", v, 0);
        wr(3, 8'h83);
        rd(0, v); chk(v == 8'h34, "R2 div lo kept", v, 8'h34);
        rd(1, v); chk(v == 8'h12, "R2 div hi kept", v, 8'h12);
        wr(3, 8'h03);

        // fixed modes, sample point 3 programmed and must be ignored (R8)
        for (int m = 0; m < 3; m++)
            for (int dv = 0; dv <= 5; dv++)
                run_cfg(m, dv, 0, 3);
        // programmable mode
        for (int dv = 1; dv <= 3; dv++) begin
            for (int e = 0; e <= 4; e++) begin
                int sc;
                sc = (1 << e) - 1;
                run_cfg(3, dv, sc, (sc >= 1) ? (sc - 1) >> 1 : 0);
                run_cfg(3, dv, sc, sc);
                run_cfg(3, dv, sc, 255);
            end
        end
        run_cfg(3, 0, 2, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule